// File: doc/BRIEF.md
# Slave Identifier Filter Bank with Match Index

This block sits beside the frame engine of a serial-bus slave node and decides, for every received frame header, which of a bank of programmable filters claims the identifier. Each filter slot carries a 6-bit identifier, a direction bit, a 3-bit data-length code, a checksum-type bit and an enable bit. Adjacent slots form pairs, and a pair can be switched from two independent exact-match entries into one identifier/mask entry that accepts a whole group of identifiers.

A received identifier enters through a valid/ready handshake. The block accepts a header only while no earlier header is pending: `hdr_ready` is low from the cycle after an accept until software clears the pending flag, or until a transmit request is taken. An offered header that is refused leaves every output unchanged, and the sender must hold it. After an accept, the block registers whether a filter hit, the match index, and the attributes of the winning slot for the frame engine. It also raises either a transmit interrupt or a receive interrupt. Software loads the data bytes and then asserts a transmit request. Frame transmission starts only if the pending header matched a transmit-direction filter.

Top module: `lif_filter_bank`

## Requirements
- R1: After reset, `hdr_flag`, `irq_rx`, `irq_tx`, `tx_start` and `match_hit` are 0, `hdr_ready` is 1 and `match_idx` holds the no-match code (all ones, 4'hF for 8 slots).
- R2: In exact mode, an enabled slot whose identifier equals the accepted identifier gives, from the cycle after the accept: `match_hit`=1, `match_idx` equal to the slot number, and `frm_dir`, `frm_len`, `frm_csum` taken from that slot. Direction 1 means transmit, 0 means receive. A length code n means n+1 bytes.
- R3: A slot whose enable bit is 0 never matches, even if its identifier is equal to the received one.
- R4: When several enabled slots match, the lowest-numbered slot wins and its number is reported.
- R5: With `pair_mask_mode[p]`=1, slot 2p holds the identifier and slot 2p+1 holds the mask in its identifier field. A mask bit of 1 means that bit is compared, and 0 means it is ignored. The pair is enabled by `slot_en[2p]` alone. A hit reports index 2p with the attributes of slot 2p, and slot 2p+1 no longer matches as an exact entry.
- R6: When no enabled slot matches, `match_hit`=0, `match_idx` is the no-match code, and `frm_dir`, `frm_len` and `frm_csum` are 0.
- R7: While `hdr_flag` is 1, `irq_tx` equals `tx_irq_en` if the header hit a transmit-direction slot, and `irq_rx` equals `rx_irq_en` otherwise. Both are 0 while the flag is 0, and they are never 1 together.
- R8: An accept sets `hdr_flag` on the next cycle. `hdr_ready` equals the inverse of `hdr_flag`, and a header offered while `hdr_ready`=0 is ignored: match index and attributes are unchanged.
- R9: A `flag_clr` pulse while `hdr_flag`=1 clears the flag on the next cycle. The match index and attributes are kept.
- R10: `xmit_req` while `hdr_flag`=1 and the header hit a transmit-direction slot gives a one-cycle `tx_start` pulse on the next cycle and clears the flag. This holds even when `flag_clr` is asserted in the same cycle. In any other state, `xmit_req` produces no pulse and leaves the flag as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hdr_valid | input | 1 | Received identifier is offered |
| hdr_ready | output | 1 | Block can take a header (no header pending) |
| hdr_id | input | 6 | Received identifier |
| slot_id | input | 48 | Identifier (or mask) of each slot, slot k in bits [6k+5:6k] |
| slot_dir | input | 8 | Direction of each slot, 1 = transmit |
| slot_len | input | 24 | Length code of each slot, slot k in bits [3k+2:3k] |
| slot_csum | input | 8 | Checksum type of each slot |
| slot_en | input | 8 | Slot enable bits |
| pair_mask_mode | input | 4 | Per-pair identifier/mask mode |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| flag_clr | input | 1 | Clears the pending header flag |
| xmit_req | input | 1 | Software data-transmit request |
| hdr_flag | output | 1 | Header received and pending |
| match_hit | output | 1 | Last accepted header hit a filter |
| match_idx | output | 4 | Index of winning slot, all ones for none |
| frm_dir | output | 1 | Direction for the frame engine |
| frm_len | output | 3 | Length code for the frame engine |
| frm_csum | output | 1 | Checksum type for the frame engine |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| tx_start | output | 1 | One-cycle start of frame transmission |

## Verification
Two actions of the pending-flag logic can fall in the same cycle: software clearing the flag and software requesting transmission. The bench asserts `flag_clr` and `xmit_req` on the same clock edge while a transmit-direction match is pending. It expects exactly one `tx_start` pulse and a cleared flag on the following cycle. A second case offers a new header while the flag is still set. The bench then checks that `hdr_ready` stays low and that the index is not overwritten until the flag is cleared.

// File: rtl/lif_pkg.sv
package lif_pkg;
  localparam int ID_W  = 6;
  localparam int LEN_W = 3;
  localparam logic DIR_TX = 1'b1;
endpackage

// File: rtl/lif_slot_pair.sv
module lif_slot_pair #(
  parameter int ID_W = lif_pkg::ID_W
) (
  input  logic [ID_W-1:0] rx_id,
  input  logic [ID_W-1:0] id_a,
  input  logic [ID_W-1:0] id_b,
  input  logic            en_a,
  input  logic            en_b,
  input  logic            mask_mode,
  output logic            hit_a,
  output logic            hit_b
);
  logic [ID_W-1:0] diff_a;
  logic [ID_W-1:0] care_a;

  assign diff_a = rx_id ^ id_a;
  // in mask mode the partner slot's identifier field is the compare mask
  assign care_a = mask_mode ? id_b : {ID_W{1'b1}};
  assign hit_a  = en_a && ((diff_a & care_a) == '0);
  assign hit_b  = !mask_mode && en_b && (rx_id == id_b);
endmodule

// File: rtl/lif_prio_pick.sv
module lif_prio_pick #(
  parameter int N = 8,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) sel = SEL_W'(k);
    end
  end
  assign any = |req;
endmodule

// File: rtl/lif_irq_ctl.sv
module lif_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic matched_tx,
  input  logic flag_clr,
  input  logic xmit_req,
  input  logic rx_irq_en,
  input  logic tx_irq_en,
  output logic flag,
  output logic irq_rx,
  output logic irq_tx,
  output logic tx_start
);
  logic go;

  assign go = xmit_req && flag && matched_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      tx_start <= go;
      if (accept) flag <= 1'b1;
      else if (flag_clr || go) flag <= 1'b0;
    end
  end

  assign irq_tx = flag && matched_tx && tx_irq_en;
  assign irq_rx = flag && !matched_tx && rx_irq_en;

  // R10
  tx_start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ($past(xmit_req) && $past(flag) && $past(matched_tx)));
  // R10
  tx_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !flag);
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && flag_clr) |=> !flag);
  // R7
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx && irq_tx));
endmodule

// File: rtl/lif_filter_bank.sv
module lif_filter_bank #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = lif_pkg::ID_W,
  parameter int LEN_W     = lif_pkg::LEN_W,
  localparam int NUM_PAIRS = NUM_SLOTS / 2,
  localparam int SEL_W     = $clog2(NUM_SLOTS),
  localparam int IDX_W     = SEL_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hdr_valid,
  output logic                       hdr_ready,
  input  logic [ID_W-1:0]            hdr_id,
  input  logic [NUM_SLOTS*ID_W-1:0]  slot_id,
  input  logic [NUM_SLOTS-1:0]       slot_dir,
  input  logic [NUM_SLOTS*LEN_W-1:0] slot_len,
  input  logic [NUM_SLOTS-1:0]       slot_csum,
  input  logic [NUM_SLOTS-1:0]       slot_en,
  input  logic [NUM_PAIRS-1:0]       pair_mask_mode,
  input  logic                       rx_irq_en,
  input  logic                       tx_irq_en,
  input  logic                       flag_clr,
  input  logic                       xmit_req,
  output logic                       hdr_flag,
  output logic                       match_hit,
  output logic [IDX_W-1:0]           match_idx,
  output logic                       frm_dir,
  output logic [LEN_W-1:0]           frm_len,
  output logic                       frm_csum,
  output logic                       irq_rx,
  output logic                       irq_tx,
  output logic                       tx_start
);
  localparam logic [IDX_W-1:0] IDX_NONE = {IDX_W{1'b1}};

  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 pick_any;
  logic [SEL_W-1:0]     pick_sel;
  logic                 accept;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    lif_slot_pair #(.ID_W(ID_W)) u_pair (
      .rx_id     (hdr_id),
      .id_a      (slot_id[(2*p)*ID_W +: ID_W]),
      .id_b      (slot_id[(2*p+1)*ID_W +: ID_W]),
      .en_a      (slot_en[2*p]),
      .en_b      (slot_en[2*p+1]),
      .mask_mode (pair_mask_mode[p]),
      .hit_a     (slot_hit[2*p]),
      .hit_b     (slot_hit[2*p+1])
    );
  end

  lif_prio_pick #(.N(NUM_SLOTS)) u_pick (
    .req (slot_hit),
    .any (pick_any),
    .sel (pick_sel)
  );

  assign hdr_ready = !hdr_flag;
  assign accept    = hdr_valid && hdr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_hit <= 1'b0;
      match_idx <= IDX_NONE;
      frm_dir   <= 1'b0;
      frm_len   <= '0;
      frm_csum  <= 1'b0;
    end else if (accept) begin
      match_hit <= pick_any;
      match_idx <= pick_any ? {1'b0, pick_sel} : IDX_NONE;
      frm_dir   <= pick_any && slot_dir[pick_sel];
      frm_len   <= pick_any ? slot_len[pick_sel*LEN_W +: LEN_W] : '0;
      frm_csum  <= pick_any && slot_csum[pick_sel];
    end
  end

  lif_irq_ctl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .matched_tx (match_hit && (frm_dir == lif_pkg::DIR_TX)),
    .flag_clr   (flag_clr),
    .xmit_req   (xmit_req),
    .rx_irq_en  (rx_irq_en),
    .tx_irq_en  (tx_irq_en),
    .flag       (hdr_flag),
    .irq_rx     (irq_rx),
    .irq_tx     (irq_tx),
    .tx_start   (tx_start)
  );

  // R8
  pending_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_flag |-> !hdr_ready);
  // R8
  pending_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_flag |=> ($stable(match_idx) && $stable(frm_len)));
  // R6
  miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_hit |-> (match_idx == IDX_NONE && !frm_dir && frm_len == '0));
  // R2
  hit_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> !match_idx[IDX_W-1]);
endmodule

// File: tb/test_lif_filter_bank.sv
module test_lif_filter_bank;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic hdr_valid = 0, hdr_ready;
  logic [5:0] hdr_id = '0;
  logic [5:0] sid [N];
  logic [2:0] slen [N];
  logic [N*6-1:0] slot_id;
  logic [N*3-1:0] slot_len;
  logic [N-1:0] slot_dir = '0, slot_csum = '0, slot_en = '0;
  logic [N/2-1:0] pair_mask_mode = '0;
  logic rx_irq_en = 1, tx_irq_en = 1, flag_clr = 0, xmit_req = 0;
  logic hdr_flag, match_hit, frm_dir, frm_csum, irq_rx, irq_tx, tx_start;
  logic [3:0] match_idx;
  logic [2:0] frm_len;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      slot_id[k*6 +: 6]  = sid[k];
      slot_len[k*3 +: 3] = slen[k];
    end
  end

  lif_filter_bank i_lif_filter_bank (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_id(hdr_id), .slot_id(slot_id), .slot_dir(slot_dir), .slot_len(slot_len),
    .slot_csum(slot_csum), .slot_en(slot_en), .pair_mask_mode(pair_mask_mode),
    .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en), .flag_clr(flag_clr),
    .xmit_req(xmit_req), .hdr_flag(hdr_flag), .match_hit(match_hit),
    .match_idx(match_idx), .frm_dir(frm_dir), .frm_len(frm_len),
    .frm_csum(frm_csum), .irq_rx(irq_rx), .irq_tx(irq_tx), .tx_start(tx_start)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      finish_run();
    end
  end

  // drive at negedge, accepted at next posedge, results sampled at following negedge
  task automatic send_hdr(logic [5:0] id);
    @(negedge clk);
    hdr_valid = 1; hdr_id = id;
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
  endtask

  task automatic reset_cfg();
    for (int k = 0; k < N; k++) begin sid[k] = '0; slen[k] = '0; end
    slot_dir = '0; slot_csum = '0; slot_en = '0; pair_mask_mode = '0;
    rx_irq_en = 1; tx_irq_en = 1;
  endtask

  task automatic t_reset();
    chk("R1 flag", hdr_flag, 0);
    chk("R1 ready", hdr_ready, 1);
    chk("R1 idx", match_idx, 15);
    chk("R1 hit", match_hit, 0);
    chk("R1 irq", {irq_rx, irq_tx, tx_start}, 0);
  endtask

  task automatic t_exact();
    reset_cfg();
    sid[3] = 6'h15; slen[3] = 3'd5; slot_dir[3] = 1; slot_csum[3] = 1; slot_en[3] = 1;
    send_hdr(6'h15);
    chk("R8 flag set", hdr_flag, 1);
    chk("R2 hit", match_hit, 1);
    chk("R2 idx", match_idx, 3);
    chk("R2 attr", {frm_dir, frm_len, frm_csum}, {1'b1, 3'd5, 1'b1});
    chk("R7 irq_tx", irq_tx, 1);
    chk("R7 irq_rx", irq_rx, 0);
    clear_flag();
    chk("R9 flag cleared", hdr_flag, 0);
    chk("R9 idx kept", match_idx, 3);
    chk("R7 irq idle", {irq_rx, irq_tx}, 0);
  endtask

  task automatic t_disabled();
    reset_cfg();
    sid[3] = 6'h15; slot_dir[3] = 1; slen[3] = 3'd2;
    send_hdr(6'h15);
    chk("R3 no hit", match_hit, 0);
    chk("R6 idx none", match_idx, 15);
    chk("R6 attr zero", {frm_dir, frm_len, frm_csum}, 0);
    chk("R7 irq_rx default", irq_rx, 1);
    chk("R7 irq_tx", irq_tx, 0);
    clear_flag();
  endtask

  task automatic t_prio();
    reset_cfg();
    sid[2] = 6'h2A; slen[2] = 3'd1; slot_en[2] = 1;
    sid[5] = 6'h2A; slen[5] = 3'd7; slot_en[5] = 1; slot_dir[5] = 1;
    sid[6] = 6'h2A; slot_en[6] = 1;
    send_hdr(6'h2A);
    chk("R4 lowest idx", match_idx, 2);
    chk("R4 lowest attr", {frm_dir, frm_len}, {1'b0, 3'd1});
    chk("R7 rx irq for rx slot", {irq_rx, irq_tx}, 2'b10);
    clear_flag();
  endtask

  task automatic t_mask();
    reset_cfg();
    pair_mask_mode[2] = 1;
    sid[4] = 6'h20; slen[4] = 3'd4; slot_csum[4] = 1; slot_en[4] = 1;
    sid[5] = 6'h30; slot_en[5] = 1; slen[5] = 3'd6;
    send_hdr(6'h2B);
    chk("R5 masked hit", match_hit, 1);
    chk("R5 pair idx", match_idx, 4);
    chk("R5 pair attr", {frm_len, frm_csum}, {3'd4, 1'b1});
    clear_flag();
    send_hdr(6'h30);
    chk("R5 mask slot not exact", match_hit, 0);
    clear_flag();
    send_hdr(6'h1B);
    chk("R5 compared bit differs", match_idx, 15);
    clear_flag();
    slot_en[4] = 0;
    send_hdr(6'h20);
    chk("R5 pair disabled", match_hit, 0);
    clear_flag();
  endtask

  task automatic t_backpressure();
    reset_cfg();
    sid[1] = 6'h05; slot_en[1] = 1; sid[7] = 6'h09; slot_en[7] = 1;
    send_hdr(6'h05);
    chk("R8 not ready", hdr_ready, 0);
    @(negedge clk); hdr_valid = 1; hdr_id = 6'h09;
    @(negedge clk); @(negedge clk);
    chk("R8 refused keeps idx", match_idx, 1);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    chk("R8 ready after clear", hdr_ready, 1);
    @(negedge clk);
    hdr_valid = 0;
    chk("R8 held header accepted", match_idx, 7);
    clear_flag();
  endtask

  task automatic t_xmit();
    reset_cfg();
    sid[0] = 6'h11; slot_dir[0] = 1; slot_en[0] = 1;
    sid[1] = 6'h12; slot_en[1] = 1;
    send_hdr(6'h11);
    xmit_req = 1;
    @(negedge clk);
    xmit_req = 0;
    chk("R10 tx_start", tx_start, 1);
    chk("R10 flag cleared", hdr_flag, 0);
    @(negedge clk);
    chk("R10 single pulse", tx_start, 0);
    send_hdr(6'h12);
    xmit_req = 1;
    @(negedge clk);
    xmit_req = 0;
    chk("R10 rx no start", tx_start, 0);
    chk("R10 rx flag kept", hdr_flag, 1);
    clear_flag();
    send_hdr(6'h11);
    xmit_req = 1; flag_clr = 1;
    @(negedge clk);
    xmit_req = 0; flag_clr = 0;
    chk("R10 start with clr", tx_start, 1);
    chk("R10 flag after both", hdr_flag, 0);
    tx_irq_en = 0;
    send_hdr(6'h11);
    chk("R7 tx irq masked", {irq_rx, irq_tx}, 0);
    clear_flag();
    rx_irq_en = 0;
    send_hdr(6'h3F);
    chk("R7 rx irq masked", {irq_rx, irq_tx}, 0);
    chk("R8 flag without irq", hdr_flag, 1);
    clear_flag();
  endtask

  initial begin
    reset_cfg();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_disabled();
    t_prio();
    t_mask();
    t_backpressure();
    t_xmit();
    finish_run();
  end
endmodule